// File: doc/BRIEF.md
# DSP Address Register Update Unit

This block keeps four 16-bit pointer registers for a signal-processing core and four 16-bit signed step registers beside them. Each cycle it may take one single-word instruction that bumps a pointer up or down by one, or moves it by the value of a step register. It decodes the word, picks the registers, works out the new pointer and stores it, all in one clock. All pointer arithmetic wraps modulo 65536, with no saturation and no flags. Circular buffers and memory access are left to other blocks.

A separate load port lets the core place any value in any pointer or step register. If the load port and an instruction aim at the same pointer in the same cycle, the instruction wins. Words that match none of the four instruction patterns change nothing and raise a one-cycle `unhandled` pulse. All four pointers can always be read on a flat output bus.

Top module: `aru_addr_update`

## Requirements
- R1: While `rst` is high at a clock edge, all pointers and step registers clear to zero and `unhandled` goes low.
- R2: The word 0x0008 + d (d = bits [1:0]) with `instr_valid` high adds 1 to pointer d at the next edge, and 0xFFFF wraps to 0x0000.
- R3: The word 0x0004 + d subtracts 1 from pointer d at the next edge, and 0x0000 wraps to 0xFFFF.
- R4: The word 0x0010 + 4*s + d (s = bits [3:2]) adds step register s, read as signed 16-bit, to pointer d modulo 65536.
- R5: The word 0x000C + d subtracts step register d (the step register with the same number) from pointer d modulo 65536.
- R6: A valid word outside these four patterns changes no register, and `unhandled` is high for exactly the one cycle after that edge.
- R7: With `instr_valid` low, the word is ignored: no register changes and `unhandled` stays low.
- R8: With `wr_en` high, `wr_data` is loaded at the next edge into pointer `wr_sel[1:0]` when `wr_sel[2]` is 0, or into step register `wr_sel[1:0]` when `wr_sel[2]` is 1.
- R9: When an instruction and the load port target the same pointer in one cycle, the instruction result is stored; a load to any other register in that cycle still takes effect.
- R10: An instruction changes only its destination pointer; `addr_flat[16*i+15:16*i]` carries pointer i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Qualifies `instr` this cycle |
| instr | input | 16 | Instruction word |
| wr_en | input | 1 | Load port enable |
| wr_sel | input | 3 | Load target: bit 2 picks step bank, bits [1:0] the register |
| wr_data | input | 16 | Load value |
| addr_flat | output | 64 | Pointer i on bits [16*i+15:16*i] |
| unhandled | output | 1 | One-cycle pulse after an unrecognised valid word |

## Verification
The hardest case to reach from the ports is the same-cycle collision of a load and an instruction on one pointer, together with a load to a different register while an instruction runs. The stimulus first sets a pointer to 0xFFFF with a decrement from zero, then drives an increment and a conflicting load to that pointer in one cycle, so the stored 0x0000 can only come from the instruction. Signed steps of 0xFFFE and 0x8000 are loaded first so that the add and subtract forms cross the wrap boundary in both directions.

// File: rtl/aru_pkg.sv
package aru_pkg;

    localparam int AW   = 16;            // pointer and step width
    localparam int NR   = 4;             // registers per bank
    localparam int RSEL = $clog2(NR);    // register select width
    localparam int OPW  = 16;            // instruction word width

    typedef logic [AW-1:0] word_t;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_INC,
        OP_DEC,
        OP_ADD,
        OP_SUB
    } op_kind_e;

    typedef struct packed {
        op_kind_e        kind;
        logic [RSEL-1:0] dst;
        logic [RSEL-1:0] src;
    } op_dec_t;

    typedef struct packed {
        logic            en;
        logic [RSEL-1:0] dst;
        word_t           value;
    } addr_upd_t;

    // Classify an instruction word. Bits [15:5] must be clear for any
    // of the recognised forms; bit 4 marks the add-step form.
    function automatic op_dec_t decode_word(logic [OPW-1:0] w);
        op_dec_t d;
        d.kind = OP_NONE;
        d.dst  = w[RSEL-1:0];
        d.src  = w[RSEL-1:0];
        if (w[OPW-1:5] == '0) begin
            if (w[4]) begin
                d.kind = OP_ADD;
                d.src  = w[2*RSEL-1:RSEL];
            end else begin
                unique case (w[3:2])
                    2'b01:   d.kind = OP_DEC;
                    2'b10:   d.kind = OP_INC;
                    2'b11:   d.kind = OP_SUB;
                    default: d.kind = OP_NONE;
                endcase
            end
        end
        return d;
    endfunction

    // Modular pointer step; the step operand is two's complement, so a
    // plain AW-bit add or subtract yields the signed wrap result.
    function automatic word_t step_ptr(op_kind_e k, word_t a, word_t ix);
        word_t r;
        unique case (k)
            OP_INC:  r = a + word_t'(1);
            OP_DEC:  r = a - word_t'(1);
            OP_ADD:  r = a + ix;
            OP_SUB:  r = a - ix;
            default: r = a;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/aru_decode.sv
module aru_decode
    import aru_pkg::*;
(
    input  logic           instr_valid,
    input  logic [OPW-1:0] instr,
    output op_dec_t        dec,
    output logic           bad_op
);
    op_dec_t raw;

    always_comb begin
        raw    = decode_word(instr);
        dec    = raw;
        bad_op = 1'b0;
        if (!instr_valid) begin
            dec.kind = OP_NONE;
        end else if (raw.kind == OP_NONE) begin
            bad_op = 1'b1;
        end
    end
endmodule

// File: rtl/aru_addr_calc.sv
module aru_addr_calc
    import aru_pkg::*;
(
    input  op_dec_t   dec,
    input  word_t     base,
    input  word_t     step,
    output addr_upd_t upd
);
    always_comb begin
        upd.en    = (dec.kind != OP_NONE);
        upd.dst   = dec.dst;
        upd.value = step_ptr(dec.kind, base, step);
    end
endmodule

// File: rtl/aru_regbank.sv
module aru_regbank
    import aru_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  addr_upd_t       upd,
    input  logic            wr_en,
    input  logic [RSEL:0]   wr_sel,
    input  word_t           wr_data,
    output word_t           ptr_q [NR],
    output word_t           stp_q [NR]
);
    for (genvar i = 0; i < NR; i++) begin : g_reg
        logic ptr_load;
        logic stp_load;
        logic ptr_upd;

        assign ptr_upd  = upd.en && (upd.dst == RSEL'(i));
        assign ptr_load = wr_en && !wr_sel[RSEL] && (wr_sel[RSEL-1:0] == RSEL'(i));
        assign stp_load = wr_en &&  wr_sel[RSEL] && (wr_sel[RSEL-1:0] == RSEL'(i));

        // Instruction result has priority over the load port.
        always_ff @(posedge clk) begin
            if (rst) begin
                ptr_q[i] <= '0;
            end else if (ptr_upd) begin
                ptr_q[i] <= upd.value;
            end else if (ptr_load) begin
                ptr_q[i] <= wr_data;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                stp_q[i] <= '0;
            end else if (stp_load) begin
                stp_q[i] <= wr_data;
            end
        end
    end
endmodule

// File: rtl/aru_addr_update.sv
module aru_addr_update
    import aru_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               instr_valid,
    input  logic [OPW-1:0]     instr,
    input  logic               wr_en,
    input  logic [RSEL:0]      wr_sel,
    input  logic [AW-1:0]      wr_data,
    output logic [NR*AW-1:0]   addr_flat,
    output logic               unhandled
);
    op_dec_t   dec;
    logic      bad_op;
    addr_upd_t upd;
    word_t     ptr_q [NR];
    word_t     stp_q [NR];
    word_t     sel_ptr;
    word_t     sel_stp;

    aru_decode u_dec (
        .instr_valid (instr_valid),
        .instr       (instr),
        .dec         (dec),
        .bad_op      (bad_op)
    );

    assign sel_ptr = ptr_q[dec.dst];
    assign sel_stp = stp_q[dec.src];

    aru_addr_calc u_calc (
        .dec  (dec),
        .base (sel_ptr),
        .step (sel_stp),
        .upd  (upd)
    );

    aru_regbank u_bank (
        .clk     (clk),
        .rst     (rst),
        .upd     (upd),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .ptr_q   (ptr_q),
        .stp_q   (stp_q)
    );

    always_ff @(posedge clk) begin
        if (rst) unhandled <= 1'b0;
        else     unhandled <= bad_op;
    end

    for (genvar i = 0; i < NR; i++) begin : g_flat
        assign addr_flat[i*AW +: AW] = ptr_q[i];
    end

    // R2: increment lands one above the previous pointer value.
    a_r2_inc_step: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(dec.kind) == OP_INC)
        |-> ptr_q[$past(dec.dst)] == word_t'($past(sel_ptr) + word_t'(1)));

    // R3: decrement lands one below the previous pointer value.
    a_r3_dec_step: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(dec.kind) == OP_DEC)
        |-> ptr_q[$past(dec.dst)] == word_t'($past(sel_ptr) - word_t'(1)));

    // R6: an unrecognised word without a load leaves every pointer intact.
    a_r6_bad_hold: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(instr_valid) && $past(dec.kind) == OP_NONE
         && !$past(wr_en))
        |-> (addr_flat == $past(addr_flat) && unhandled));

    // R7: an idle cycle without a load changes nothing and raises no pulse.
    a_r7_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(instr_valid) && !$past(wr_en))
        |-> (addr_flat == $past(addr_flat) && !unhandled));
endmodule

// File: tb/aru_addr_update_test.sv
module aru_addr_update_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        instr_valid = 1'b0;
    logic [15:0] instr = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [15:0] wr_data = '0;
    logic [63:0] addr_flat;
    logic        unhandled;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;   // 100 MHz

    aru_addr_update uut (
        .clk         (clk),
        .rst         (rst),
        .instr_valid (instr_valid),
        .instr       (instr),
        .wr_en       (wr_en),
        .wr_sel      (wr_sel),
        .wr_data     (wr_data),
        .addr_flat   (addr_flat),
        .unhandled   (unhandled)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic        we;
        logic [2:0]  ws;
        logic [15:0] wd;
        logic        iv;
        logic [15:0] ins;
        logic [63:0] exp_ptr;   // {p3, p2, p1, p0}
        logic        exp_unh;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VEC [NV] = '{
        '{4'd8,  1'b1, 3'd0, 16'h1000, 1'b0, 16'h0000, 64'h0000_0000_0000_1000, 1'b0}, // R8 p0
        '{4'd8,  1'b1, 3'd1, 16'hFFFF, 1'b0, 16'h0000, 64'h0000_0000_FFFF_1000, 1'b0}, // R8 p1
        '{4'd8,  1'b1, 3'd4, 16'h0010, 1'b0, 16'h0000, 64'h0000_0000_FFFF_1000, 1'b0}, // R8 s0
        '{4'd8,  1'b1, 3'd5, 16'hFFFE, 1'b0, 16'h0000, 64'h0000_0000_FFFF_1000, 1'b0}, // R8 s1
        '{4'd8,  1'b1, 3'd6, 16'h8000, 1'b0, 16'h0000, 64'h0000_0000_FFFF_1000, 1'b0}, // R8 s2
        '{4'd2,  1'b0, 3'd0, 16'h0000, 1'b1, 16'h0009, 64'h0000_0000_0000_1000, 1'b0}, // R2 wrap
        '{4'd3,  1'b0, 3'd0, 16'h0000, 1'b1, 16'h0006, 64'h0000_FFFF_0000_1000, 1'b0}, // R3 wrap
        '{4'd4,  1'b0, 3'd0, 16'h0000, 1'b1, 16'h0014, 64'h0000_FFFF_0000_0FFE, 1'b0}, // R4 neg
        '{4'd4,  1'b0, 3'd0, 16'h0000, 1'b1, 16'h0013, 64'h0010_FFFF_0000_0FFE, 1'b0}, // R4 pos
        '{4'd5,  1'b0, 3'd0, 16'h0000, 1'b1, 16'h000C, 64'h0010_FFFF_0000_0FEE, 1'b0}, // R5 pos
        '{4'd5,  1'b0, 3'd0, 16'h0000, 1'b1, 16'h000D, 64'h0010_FFFF_0002_0FEE, 1'b0}, // R5 neg
        '{4'd6,  1'b0, 3'd0, 16'h0000, 1'b1, 16'h0003, 64'h0010_FFFF_0002_0FEE, 1'b1}, // R6
        '{4'd6,  1'b0, 3'd0, 16'h0000, 1'b1, 16'h0020, 64'h0010_FFFF_0002_0FEE, 1'b1}, // R6
        '{4'd7,  1'b0, 3'd0, 16'h0000, 1'b0, 16'h0008, 64'h0010_FFFF_0002_0FEE, 1'b0}, // R7
        '{4'd9,  1'b1, 3'd2, 16'h1234, 1'b1, 16'h000A, 64'h0010_0000_0002_0FEE, 1'b0}, // R9 same
        '{4'd9,  1'b1, 3'd0, 16'h5555, 1'b1, 16'h000B, 64'h0011_0000_0002_5555, 1'b0}, // R9 other
        '{4'd4,  1'b0, 3'd0, 16'h0000, 1'b1, 16'h001A, 64'h0011_8000_0002_5555, 1'b0}, // R4
        '{4'd4,  1'b0, 3'd0, 16'h0000, 1'b1, 16'h001A, 64'h0011_0000_0002_5555, 1'b0}, // R4 wrap
        '{4'd10, 1'b0, 3'd0, 16'h0000, 1'b1, 16'h000F, 64'h0011_0000_0002_5555, 1'b0}, // R10
        '{4'd6,  1'b0, 3'd0, 16'h0000, 1'b1, 16'hFFFF, 64'h0011_0000_0002_5555, 1'b1}  // R6
    };

    task automatic check(input string req, input logic [63:0] exp_ptr,
                         input logic exp_unh);
        checks++;
        if (addr_flat !== exp_ptr || unhandled !== exp_unh) begin
            fails++;
            $display("FAIL %s: ptr=%h unh=%b expected ptr=%h unh=%b",
                     req, addr_flat, unhandled, exp_ptr, exp_unh);
        end
    endtask

    task automatic drive(input logic we, input logic [2:0] ws, input logic [15:0] wd,
                         input logic iv, input logic [15:0] ins);
        @(negedge clk);
        wr_en = we; wr_sel = ws; wr_data = wd;
        instr_valid = iv; instr = ins;
        @(posedge clk);
        #1;
        wr_en = 1'b0; instr_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1", 64'h0, 1'b0);             // reset state
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].we, VEC[i].ws, VEC[i].wd, VEC[i].iv, VEC[i].ins);
            check($sformatf("R%0d", VEC[i].req), VEC[i].exp_ptr, VEC[i].exp_unh);
        end

        // R6: pulse lasts one cycle only
        drive(1'b0, 3'd0, 16'h0, 1'b1, 16'h0100);
        check("R6", 64'h0011_0000_0002_5555, 1'b1);
        drive(1'b0, 3'd0, 16'h0, 1'b0, 16'h0000);
        check("R6", 64'h0011_0000_0002_5555, 1'b0);

        // R1: mid-run reset clears pointers and steps
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check("R1", 64'h0, 1'b0);
        @(negedge clk);
        rst = 1'b0;
        drive(1'b1, 3'd1, 16'h0007, 1'b0, 16'h0000);
        check("R8", 64'h0000_0000_0007_0000, 1'b0);
        drive(1'b0, 3'd0, 16'h0, 1'b1, 16'h0015);   // p1 += s1, s1 cleared
        check("R1", 64'h0000_0000_0007_0000, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule